// File: doc/BRIEF.md
# Rotating / Fixed Priority Request Arbiter

This block picks one winner among `1 << CHN_BITS` request lines and announces it with a one-cycle, one-hot grant pulse plus the binary index of the winner. A build-time parameter selects the priority scheme. In rotating mode, the channel just after the most recent winner is examined first, so every requester gets a turn. In fixed mode, the lowest-numbered requester always wins.

A decision is taken only while the enable input is high. The caller is expected to drop the enable once it sees the grant, and to raise it again when it is ready for the next decision. To keep a held enable from producing a stream of grants, the arbiter stays silent for the cycle right after any grant. A synchronous reset clears the pulse and the stored index. In rotating mode the next search after a reset therefore begins at channel 1.

Top module: `prio_arbiter`

## Requirements
- R1: With ARB_MODE = ARB_ROTATE (encoding 0), the winner is the first requesting channel found when searching upward from (stored index + 1), wrapping from the top channel to channel 0.
- R2: With ARB_MODE = ARB_FIXED (encoding 1), the winner is the requesting channel with the lowest index.
- R3: `grant` has at most one bit set, and a grant is a pulse that lasts exactly one clock. It appears on the clock edge at which the enable and requests are sampled.
- R4: `grant_chn` holds the index of the bit set in `grant` during the grant cycle, and it keeps that value until the next grant.
- R5: While `srst` is high at a clock edge, `grant` becomes 0 and `grant_chn` becomes 0. After reset in rotating mode, channel 1 is searched first.
- R6: No grant is issued at an edge where `arb_en` is low or no `req` bit is set, and `grant_chn` is left unchanged.
- R7: At the edge right after a grant, no grant is issued, even when `arb_en` and requests are still high.
- R8: The block has 1 << CHN_BITS request and grant lines, and `grant_chn` is CHN_BITS wide. The top channel can be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| arb_en | input | 1 | Allows a decision at this edge |
| req | input | 1<<CHN_BITS | Request per channel |
| grant | output | 1<<CHN_BITS | One-hot single-cycle grant pulse |
| grant_chn | output | CHN_BITS | Index of the latest winner, held |

## Verification
The only internal state is the stored index and the last grant pulse, and both are visible at the ports. A corrupted stored index shows up in rotating mode at the next contended grant, because the wrong channel wins. This is caught within one decision. A pulse register that fails to clear shows up as a second grant on the edge right after a grant, or as a grant with no request. The bench compares both outputs every cycle against a model, so such faults appear within one clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_ROTATE = 1'b0,
    ARB_FIXED  = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_pick_fixed.sv
module arb_pick_fixed #(
  parameter int CHN_BITS = 2,
  localparam int NCH = 1 << CHN_BITS
) (
  input  logic [NCH-1:0]      req,
  output logic                found,
  output logic [CHN_BITS-1:0] idx
);
  function automatic logic [CHN_BITS:0] lowest_set(input logic [NCH-1:0] r);
    logic [CHN_BITS:0] res;
    res = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (r[k]) res = {1'b1, CHN_BITS'(k)};
    end
    return res;
  endfunction

  always_comb begin
    {found, idx} = lowest_set(req);
  end
endmodule

// File: rtl/arb_pick_rotate.sv
module arb_pick_rotate #(
  parameter int CHN_BITS = 2,
  localparam int NCH = 1 << CHN_BITS
) (
  input  logic [NCH-1:0]      req,
  input  logic [CHN_BITS-1:0] last,
  output logic                found,
  output logic [CHN_BITS-1:0] idx
);
  function automatic logic [CHN_BITS:0] search_after(input logic [NCH-1:0] r,
                                                     input logic [CHN_BITS-1:0] l);
    logic [CHN_BITS:0]   res;
    logic [CHN_BITS-1:0] c;
    res = '0;
    for (int k = 1; k <= NCH; k++) begin
      c = l + CHN_BITS'(k);
      if (!res[CHN_BITS] && r[c]) res = {1'b1, c};
    end
    return res;
  endfunction

  always_comb begin
    {found, idx} = search_after(req, last);
  end
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
  parameter int CHN_BITS = 2,
  localparam int NCH = 1 << CHN_BITS
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                take,
  input  logic [CHN_BITS-1:0] win_idx,
  output logic [NCH-1:0]      grant,
  output logic [CHN_BITS-1:0] grant_chn
);
  always_ff @(posedge clk) begin
    if (srst) begin
      grant     <= '0;
      grant_chn <= '0;
    end else if (take) begin
      grant     <= NCH'(1) << win_idx;
      grant_chn <= win_idx;
    end else begin
      grant     <= '0;
    end
  end

  // R3: pulse never carries more than one channel
  a_r3_onehot: assert property (@(posedge clk) disable iff (srst)
    $onehot0(grant));

  // R4: index agrees with the pulse
  a_r4_chn_matches: assert property (@(posedge clk) disable iff (srst)
    (|grant) |-> grant[grant_chn]);

  // R4: index held between grants
  a_r4_chn_held: assert property (@(posedge clk) disable iff (srst)
    !(|grant) |-> $stable(grant_chn));
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import arb_pkg::*;
#(
  parameter arb_mode_e ARB_MODE = ARB_ROTATE,
  parameter int        CHN_BITS = 2,
  localparam int       NCH      = 1 << CHN_BITS
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                arb_en,
  input  logic [NCH-1:0]      req,
  output logic [NCH-1:0]      grant,
  output logic [CHN_BITS-1:0] grant_chn
);
  logic                found;
  logic [CHN_BITS-1:0] win_idx;
  logic                grant_busy;
  logic                take;

  generate
    if (ARB_MODE == ARB_FIXED) begin : g_fixed
      arb_pick_fixed #(.CHN_BITS(CHN_BITS)) u_pick (
        .req   (req),
        .found (found),
        .idx   (win_idx)
      );
    end else begin : g_rotate
      arb_pick_rotate #(.CHN_BITS(CHN_BITS)) u_pick (
        .req   (req),
        .last  (grant_chn),
        .found (found),
        .idx   (win_idx)
      );
    end
  endgenerate

  assign grant_busy = |grant;
  assign take       = arb_en && found && !grant_busy;

  arb_grant_reg #(.CHN_BITS(CHN_BITS)) u_state (
    .clk       (clk),
    .srst      (srst),
    .take      (take),
    .win_idx   (win_idx),
    .grant     (grant),
    .grant_chn (grant_chn)
  );

  // R6: nothing granted when disabled or idle
  a_r6_idle: assert property (@(posedge clk) disable iff (srst)
    (!arb_en || req == '0) |=> grant == '0);

  // R7: a grant is never followed by another one
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (srst)
    (|grant) |=> grant == '0);

  // R3: an eligible request is always served at the next edge
  a_r3_served: assert property (@(posedge clk) disable iff (srst)
    (arb_en && req != '0 && grant == '0) |=> (|grant));

  generate
    if (ARB_MODE == ARB_FIXED) begin : g_fixed_chk
      // R2: no lower-numbered channel was requesting
      a_r2_lowest_wins: assert property (@(posedge clk) disable iff (srst)
        (|grant) |-> (($past(req) & (grant - NCH'(1))) == '0));
    end
  endgenerate
endmodule

// File: tb/prio_arbiter_bench.sv
module prio_arbiter_bench;
  import arb_pkg::*;
  localparam int CB  = 2;
  localparam int NCH = 1 << CB;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic arb_en = 1'b0;
  logic [NCH-1:0] req = '0;
  logic [NCH-1:0] g_rr, g_fx;
  logic [CB-1:0]  c_rr, c_fx;

  int n_chk = 0;
  int n_bad = 0;

  logic [CB-1:0] m_last_rr = '0, m_last_fx = '0;
  logic          m_busy_rr = 1'b0, m_busy_fx = 1'b0;

  always #4 clk = ~clk;

  prio_arbiter #(.ARB_MODE(ARB_ROTATE), .CHN_BITS(CB)) u_prio_arbiter (
    .clk(clk), .srst(srst), .arb_en(arb_en), .req(req),
    .grant(g_rr), .grant_chn(c_rr));

  prio_arbiter #(.ARB_MODE(ARB_FIXED), .CHN_BITS(CB)) u_prio_arbiter_fixed (
    .clk(clk), .srst(srst), .arb_en(arb_en), .req(req),
    .grant(g_fx), .grant_chn(c_fx));

  function automatic int model_pick(input logic [NCH-1:0] r, input logic [CB-1:0] last,
                                    input bit fixed);
    int i;
    if (r == '0) return -1;
    for (int k = 0; k < NCH; k++) begin
      i = fixed ? k : (int'(last) + 1 + k) % NCH;
      if (r[i]) return i;
    end
    return -1;
  endfunction

  task automatic compare(input string tag, input logic [NCH-1:0] ag, input logic [CB-1:0] ac,
                         input logic [NCH-1:0] eg, input logic [CB-1:0] ec);
    n_chk++;
    if (ag !== eg || ac !== ec) begin
      n_bad++;
      $display("FAIL %s: grant=%b chn=%0d expected grant=%b chn=%0d", tag, ag, ac, eg, ec);
    end
  endtask

  // apply inputs at negedge, compare just after the next posedge
  task automatic step(input logic en, input logic [NCH-1:0] r, input string tag);
    logic [NCH-1:0] e_rr, e_fx;
    int w;
    @(negedge clk);
    arb_en = en;
    req    = r;
    e_rr = '0;
    e_fx = '0;
    w = model_pick(r, m_last_rr, 1'b0);
    if (en && !m_busy_rr && w >= 0) begin
      e_rr = NCH'(1) << w;
      m_last_rr = CB'(w);
    end
    w = model_pick(r, m_last_fx, 1'b1);
    if (en && !m_busy_fx && w >= 0) begin
      e_fx = NCH'(1) << w;
      m_last_fx = CB'(w);
    end
    m_busy_rr = |e_rr;
    m_busy_fx = |e_fx;
    @(posedge clk);
    #1;
    compare({tag, " rotate"}, g_rr, c_rr, e_rr, m_last_rr);
    compare({tag, " fixed"},  g_fx, c_fx, e_fx, m_last_fx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    srst = 1'b1;
    arb_en = 1'b1;
    req = '1;
    repeat (2) @(posedge clk);
    #1;
    m_last_rr = '0; m_last_fx = '0; m_busy_rr = 1'b0; m_busy_fx = 1'b0;
    compare("R5 reset rotate", g_rr, c_rr, '0, '0);
    compare("R5 reset fixed",  g_fx, c_fx, '0, '0);
    @(negedge clk);
    srst = 1'b0;
    arb_en = 1'b0;
    req = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    step(1'b1, 4'b1111, "R5 first search at channel 1");
    step(1'b1, 4'b1111, "R7 held enable no regrant");
    step(1'b0, 4'b1111, "R6 enable low");
    step(1'b1, 4'b0000, "R6 no request");
    step(1'b1, 4'b1000, "R8 top channel granted");
    step(1'b0, 4'b0000, "R4 index held");
    step(1'b1, 4'b0101, "R1 wrap to channel 0");
    step(1'b0, 4'b0000, "R4 index held");
    step(1'b1, 4'b0101, "R1 skip to channel 2 R2 lowest");
    step(1'b0, 4'b0000, "gap");
    step(1'b1, 4'b0110, "R2 fixed picks 1");
    for (int i = 0; i < 6; i++) step(1'b1, 4'b1111, "R1 R7 rotation under held enable");
    do_reset();
    step(1'b1, 4'b0001, "R5 after second reset");
    for (int i = 0; i < 3000; i++) begin
      logic en;
      logic [NCH-1:0] r;
      en = ($urandom % 4) != 0;
      r  = NCH'($urandom);
      step(en, r, "R1 R2 R3 R4 random");
      if (($urandom % 500) == 0) do_reset();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule